// File: doc/BRIEF.md
# PCI Configuration Access Decoder

This block sits between a host access path and a set of up to sixteen device configuration targets. A host reaches configuration space in one of two ways. It can use a flat memory-mapped window, where the access offset itself carries the bus, device, function and register fields. It can also use a small legacy I/O block with eight bytes: a 32-bit address register that software loads piece by piece, followed by a four-byte data window. The decoder extracts the target fields from whichever path was used and checks that the target exists. For an existing target it issues a single-dword request with byte enables toward the selected slot.

Each accepted access produces one response on the following cycle. A read of a device that does not exist returns all ones at the access width. A write to a device that does not exist completes quietly and reaches no target. An access outside both address spaces, or one with an illegal size code, is answered with an error flag and zero data. The address register of the legacy path can be written and read at any byte offset and width. Bytes that an access does not cover keep their value.

Top module: `cfg_access_decoder`

## Requirements
- R1: After reset the latched 32-bit config address is zero and `rsp_valid` is low.
- R2: For a memory-window access (`acc_space`=0) the offset is decoded as bus = bits 27:20, device = bits 19:15, function = bits 14:12, register = bits 11:0. A request goes to slot = device with dword index `tgt_dw` = register bits 11:2.
- R3: An access is an error when the size code is 3, when a memory offset is at or above NUM_BUSES·1 MiB (1 MiB by default), or when a port offset (`acc_space`=1) is 8 or above. The response then has `rsp_err`=1 and `rsp_rdata`=0, no target request is made and the latched address does not change.
- R4: A write of N bytes (size code 0/1/2 means N = 1/2/4) at port offset k in 0..3 replaces latched-address bytes k..min(k+N-1,3) with write-data bytes 0..; all other bytes keep their value.
- R5: A read of N bytes at port offset k in 0..3 returns the latched address shifted right by 8k and masked to 8N bits.
- R6: A port access at offset 4..7 uses the latched address as bus = bits 23:16, device = bits 15:11, function = bits 10:8. Its register offset is latched bits 7:0 plus (offset − 4).
- R7: A target exists only when bus = 0, function = 0, device < NUM_SLOTS and `slot_present[device]` = 1. `tgt_req` is raised during an accepted access exactly for existing targets.
- R8: A read of a non-existent target returns all ones masked to the access width (0xFF, 0xFFFF or 0xFFFFFFFF) with `rsp_err`=0.
- R9: A write to a non-existent target raises no `tgt_req` and responds with `rsp_err`=0 and `rsp_rdata`=0.
- R10: With lane = register bits 1:0, `tgt_be` is the N-bit mask shifted left by lane and cut to 4 bits, and `tgt_wdata` is `acc_wdata` shifted left by 8·lane. Read data is `tgt_rdata` shifted right by 8·lane and masked to 8N bits. Any write, to a port or to a target, returns `rsp_rdata`=0.
- R11: `rsp_valid` is high in exactly the cycle after each cycle with `acc_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_present | input | NUM_SLOTS | Per-slot population flags |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_space | input | 1 | 0 = memory window, 1 = legacy port block |
| acc_addr | input | 32 | Offset into the selected space |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Write data, right-aligned |
| tgt_req | output | 1 | Request to the selected slot |
| tgt_slot | output | SLOT_W | Selected slot number |
| tgt_dw | output | 10 | Dword index within the slot's configuration space |
| tgt_wr | output | 1 | Request is a write |
| tgt_be | output | 4 | Byte enables of the request |
| tgt_wdata | output | 32 | Lane-aligned write data |
| tgt_rdata | input | 32 | Dword returned by the selected slot in the same cycle |
| rsp_valid | output | 1 | Response strobe |
| rsp_err | output | 1 | Access was outside both spaces or had an illegal size |
| rsp_rdata | output | 32 | Right-aligned read data |

## Verification
Assertions check on every cycle that responses trail accesses by exactly one cycle and that a request never reaches an absent slot. They also check that illegal-size accesses never raise a request, that error responses carry zero data, that single-byte requests enable one lane, and that the address latch changes only on a port write and a single-byte write leaves the upper bytes alone. The values themselves are shown only by the bench scenarios. These are the field decode of both paths, the accumulation of partial address writes including a write that runs past the top byte, the register offset on the data window, and the width-masked all-ones answer for missing devices.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;

   typedef enum logic [1:0] {
      SZ_ONE  = 2'd0,
      SZ_TWO  = 2'd1,
      SZ_FOUR = 2'd2,
      SZ_BAD  = 2'd3
   } acc_size_e;

   typedef struct packed {
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [11:0] regofs;
   } cfg_tgt_t;

   function automatic logic [2:0] size_bytes(input acc_size_e sz);
      case (sz)
         SZ_ONE:  return 3'd1;
         SZ_TWO:  return 3'd2;
         SZ_FOUR: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic [31:0] size_mask(input acc_size_e sz);
      case (sz)
         SZ_ONE:  return 32'h0000_00FF;
         SZ_TWO:  return 32'h0000_FFFF;
         SZ_FOUR: return 32'hFFFF_FFFF;
         default: return 32'h0000_0000;
      endcase
   endfunction

   function automatic logic [3:0] size_lanes(input acc_size_e sz);
      case (sz)
         SZ_ONE:  return 4'b0001;
         SZ_TWO:  return 4'b0011;
         SZ_FOUR: return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
   import cfg_dec_pkg::*;
#(
   parameter int LATCH_BYTES = 4,
   localparam int LW    = 8 * LATCH_BYTES,
   localparam int OFF_W = $clog2(LATCH_BYTES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OFF_W-1:0] byte_off,
   input  acc_size_e        size,
   input  logic [LW-1:0]    wdata,
   output logic [LW-1:0]    q,
   output logic [LW-1:0]    rd_data
);

   if (LATCH_BYTES != 4) begin : g_bad_width
      $error("cfg_addr_latch: LATCH_BYTES must be 4");
   end

   logic [2:0]    nbytes;
   logic [LW-1:0] wshift;

   assign nbytes  = size_bytes(size);
   assign wshift  = wdata << {byte_off, 3'b000};
   assign rd_data = (q >> {byte_off, 3'b000}) & size_mask(size);

   for (genvar b = 0; b < LATCH_BYTES; b++) begin : g_lane
      logic       hit;
      logic [7:0] byte_q;
      logic [2:0] rel;

      assign rel = 3'(b) - {1'b0, byte_off};
      assign hit = (3'(b) >= {1'b0, byte_off}) && (rel < nbytes);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q <= 8'h00;
         else if (wr_en && hit)
            byte_q <= wshift[8*b +: 8];
      end

      assign q[8*b +: 8] = byte_q;
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q)); // R4

   AST_LATCH_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && size == SZ_ONE && byte_off == '0) |=> (q[LW-1:8] == $past(q[LW-1:8]))); // R4

endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
   import cfg_dec_pkg::*;
#(
   parameter int NUM_BUSES = 1,
   parameter int PORT_SPAN = 8,
   localparam logic [32:0] WIN_LIMIT = 33'(NUM_BUSES) << 20
)(
   input  logic        acc_space,
   input  logic [31:0] acc_addr,
   input  acc_size_e   acc_size,
   input  logic [31:0] latch_q,
   output logic        acc_err,
   output logic        addr_port,
   output cfg_tgt_t    tgt
);

   if (NUM_BUSES < 1 || NUM_BUSES > 256) begin : g_bad_bus
      $error("cfg_target_decode: NUM_BUSES out of 1..256");
   end
   if (PORT_SPAN != 8) begin : g_bad_span
      $error("cfg_target_decode: PORT_SPAN must be 8");
   end

   logic in_win;
   logic in_port;

   if (NUM_BUSES == 256) begin : g_full_win
      assign in_win = (acc_addr[31:28] == 4'h0);
   end else begin : g_part_win
      assign in_win = ({1'b0, acc_addr} < WIN_LIMIT);
   end

   assign in_port = (acc_addr < 32'(PORT_SPAN));

   always_comb begin
      acc_err   = (acc_size == SZ_BAD) || (acc_space ? !in_port : !in_win);
      addr_port = acc_space && !acc_addr[2];
      if (acc_space) begin
         tgt.bus    = latch_q[23:16];
         tgt.dev    = latch_q[15:11];
         tgt.fn     = latch_q[10:8];
         tgt.regofs = {4'h0, latch_q[7:0]} + {10'h000, acc_addr[1:0]};
      end else begin
         tgt.bus    = acc_addr[27:20];
         tgt.dev    = acc_addr[19:15];
         tgt.fn     = acc_addr[14:12];
         tgt.regofs = acc_addr[11:0];
      end
   end

endmodule

// File: rtl/cfg_slot_presence.sv
module cfg_slot_presence
   import cfg_dec_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
   input  cfg_tgt_t             tgt,
   input  logic [NUM_SLOTS-1:0] present,
   output logic                 exists,
   output logic [SLOT_W-1:0]    slot
);

   if (NUM_SLOTS < 1 || NUM_SLOTS > 32) begin : g_bad_slots
      $error("cfg_slot_presence: NUM_SLOTS out of 1..32");
   end

   logic [31:0] pres_ext;

   if (NUM_SLOTS == 32) begin : g_full
      assign pres_ext = present;
   end else begin : g_pad
      assign pres_ext = {{(32 - NUM_SLOTS){1'b0}}, present};
   end

   assign exists = (tgt.bus == 8'h00) && (tgt.fn == 3'd0) && pres_ext[tgt.dev];
   assign slot   = tgt.dev[SLOT_W-1:0];

endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder
   import cfg_dec_pkg::*;
#(
   parameter int NUM_SLOTS = 16,
   parameter int NUM_BUSES = 1,
   parameter int PORT_SPAN = 8,
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SLOTS-1:0] slot_present,
   input  logic                 acc_valid,
   input  logic                 acc_space,
   input  logic [31:0]          acc_addr,
   input  logic [1:0]           acc_size,
   input  logic                 acc_wr,
   input  logic [31:0]          acc_wdata,
   output logic                 tgt_req,
   output logic [SLOT_W-1:0]    tgt_slot,
   output logic [9:0]           tgt_dw,
   output logic                 tgt_wr,
   output logic [3:0]           tgt_be,
   output logic [31:0]          tgt_wdata,
   input  logic [31:0]          tgt_rdata,
   output logic                 rsp_valid,
   output logic                 rsp_err,
   output logic [31:0]          rsp_rdata
);

   acc_size_e   size_e;
   logic [31:0] latch_q;
   logic [31:0] latch_rd;
   logic        acc_err;
   logic        addr_port;
   cfg_tgt_t    tgt;
   logic        exists;
   logic        latch_we;
   logic [1:0]  lane;
   logic [6:0]  be_wide;
   logic [31:0] amask;
   logic [31:0] rd_next;

   assign size_e = acc_size_e'(acc_size);

   cfg_target_decode #(
      .NUM_BUSES (NUM_BUSES),
      .PORT_SPAN (PORT_SPAN)
   ) i_decode (
      .acc_space (acc_space),
      .acc_addr  (acc_addr),
      .acc_size  (size_e),
      .latch_q   (latch_q),
      .acc_err   (acc_err),
      .addr_port (addr_port),
      .tgt       (tgt)
   );

   assign latch_we = acc_valid && !acc_err && addr_port && acc_wr;

   cfg_addr_latch #(
      .LATCH_BYTES (4)
   ) i_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (latch_we),
      .byte_off (acc_addr[1:0]),
      .size     (size_e),
      .wdata    (acc_wdata),
      .q        (latch_q),
      .rd_data  (latch_rd)
   );

   cfg_slot_presence #(
      .NUM_SLOTS (NUM_SLOTS)
   ) i_presence (
      .tgt     (tgt),
      .present (slot_present),
      .exists  (exists),
      .slot    (tgt_slot)
   );

   assign lane      = tgt.regofs[1:0];
   assign amask     = size_mask(size_e);
   assign be_wide   = {3'b000, size_lanes(size_e)} << lane;
   assign tgt_be    = be_wide[3:0];
   assign tgt_dw    = tgt.regofs[11:2];
   assign tgt_wr    = acc_wr;
   assign tgt_wdata = acc_wdata << {lane, 3'b000};
   assign tgt_req   = acc_valid && !acc_err && !addr_port && exists;

   always_comb begin
      if (acc_err || acc_wr)
         rd_next = 32'h0;
      else if (addr_port)
         rd_next = latch_rd;
      else if (!exists)
         rd_next = amask;
      else
         rd_next = (tgt_rdata >> {lane, 3'b000}) & amask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= 32'h0;
      end else begin
         rsp_valid <= acc_valid;
         rsp_err   <= acc_valid && acc_err;
         rsp_rdata <= acc_valid ? rd_next : 32'h0;
      end
   end

   AST_REQ_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req |-> slot_present[tgt_slot]); // R7

   AST_BAD_SIZE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_size == 2'd3) |-> !tgt_req); // R3

   AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == 32'h0)); // R3

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid); // R11

   AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !rsp_valid); // R11

   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_req && acc_size == 2'd0) |-> ($countones(tgt_be) == 1)); // R10

endmodule

// File: tb/test_cfg_access_decoder.sv
module test_cfg_access_decoder;

   localparam int CLK_PERIOD = 10;
   localparam int NSLOT      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] slot_present = 16'h0;
   logic        acc_valid = 1'b0, acc_space = 1'b0, acc_wr = 1'b0;
   logic [31:0] acc_addr = 32'h0, acc_wdata = 32'h0;
   logic [1:0]  acc_size = 2'd0;
   logic        tgt_req, tgt_wr;
   logic [3:0]  tgt_slot, tgt_be;
   logic [9:0]  tgt_dw;
   logic [31:0] tgt_wdata, tgt_rdata;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int          n_checks = 0;
   int          n_errors = 0;
   logic [31:0] mlatch = 32'h0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] pattern(input logic [3:0] s, input logic [9:0] dw);
      return {s, 2'b10, dw, 16'h5A3C};
   endfunction

   function automatic logic [31:0] wmask(input int n);
      return (n >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 32'h1);
   endfunction

   assign tgt_rdata = pattern(tgt_slot, tgt_dw);

   cfg_access_decoder i_cfg_access_decoder (
      .clk(clk), .rst_n(rst_n), .slot_present(slot_present),
      .acc_valid(acc_valid), .acc_space(acc_space), .acc_addr(acc_addr),
      .acc_size(acc_size), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .tgt_req(tgt_req), .tgt_slot(tgt_slot), .tgt_dw(tgt_dw), .tgt_wr(tgt_wr),
      .tgt_be(tgt_be), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic access(input logic sp, input logic [31:0] ad, input logic [1:0] sz,
                         input logic wr, input logic [31:0] wd);
      int          nb;
      bit          err, aport, ex;
      logic [7:0]  bus;
      logic [4:0]  dev;
      logic [2:0]  fn;
      logic [11:0] rg;
      logic [1:0]  ln;
      logic [31:0] erd, ewd;
      logic [3:0]  ebe;
      string       ftag, dtag;
      nb    = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      err   = (sz == 2'd3) || (sp ? (ad >= 32'd8) : (ad >= 32'h0010_0000));
      aport = !err && sp && (ad < 32'd4);
      ex = 1'b0; bus = 8'h0; dev = 5'h0; fn = 3'h0; rg = 12'h0;
      ftag = "R2";
      if (!err && !aport) begin
         if (sp) begin
            bus = mlatch[23:16]; dev = mlatch[15:11]; fn = mlatch[10:8];
            rg = 12'(mlatch[7:0]) + 12'(ad) - 12'd4;
            ftag = "R6";
         end else begin
            bus = ad[27:20]; dev = ad[19:15]; fn = ad[14:12]; rg = ad[11:0];
         end
         ex = (bus == 8'h0) && (fn == 3'h0) && (int'(dev) < NSLOT) && slot_present[dev[3:0]];
      end
      ln  = rg[1:0];
      ebe = 4'h0;
      for (int i = 0; i < nb; i++) if (int'(ln) + i < 4) ebe[int'(ln) + i] = 1'b1;
      ewd = wd << (8*int'(ln));
      if (err) begin erd = 32'h0; dtag = "R3"; end
      else if (wr) begin erd = 32'h0; dtag = aport ? "R4" : (ex ? "R10" : "R9"); end
      else if (aport) begin erd = (mlatch >> (8*ad)) & wmask(nb); dtag = "R5"; end
      else if (!ex) begin erd = wmask(nb); dtag = "R8"; end
      else begin erd = (pattern(dev[3:0], rg[11:2]) >> (8*int'(ln))) & wmask(nb); dtag = "R10"; end

      @(negedge clk);
      acc_valid = 1'b1; acc_space = sp; acc_addr = ad; acc_size = sz; acc_wr = wr; acc_wdata = wd;
      #1;
      check(tgt_req === ex, (wr && !ex) ? "R9" : "R7", "tgt_req", 32'(tgt_req), 32'(ex));
      if (ex) begin
         check({tgt_slot, tgt_dw} === {dev[3:0], rg[11:2]}, ftag, "slot/dword",
               32'({tgt_slot, tgt_dw}), 32'({dev[3:0], rg[11:2]}));
         check(tgt_be === ebe && tgt_wr === wr, "R10", "byte enables",
               32'(tgt_be), 32'(ebe));
         if (wr) check(tgt_wdata === ewd, "R10", "write lanes", tgt_wdata, ewd);
      end
      if (aport && wr)
         for (int i = 0; i < nb; i++)
            if (int'(ad) + i < 4) mlatch[8*(int'(ad) + i) +: 8] = wd[8*i +: 8];

      @(negedge clk);
      check(rsp_valid === 1'b1, "R11", "rsp_valid", 32'(rsp_valid), 32'h1);
      check(rsp_err === err, "R3", "rsp_err", 32'(rsp_err), 32'(err));
      check(rsp_rdata === erd, dtag, "rsp_rdata", rsp_rdata, erd);
      acc_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin : main
      logic [31:0] ad;
      void'($urandom(32'd7919));
      repeat (3) @(negedge clk);
      check(rsp_valid === 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
      acc_valid = 1'b1; acc_space = 1'b1; acc_addr = 32'd0; acc_size = 2'd2; acc_wr = 1'b0;
      @(negedge clk);
      check(rsp_rdata === 32'h0, "R1", "latched address after reset", rsp_rdata, 32'h0);
      acc_valid = 1'b0;

      slot_present = 16'b0000_0000_0010_0101;
      // R2 memory window decode, existing and missing devices
      access(1'b0, {12'h0, 5'd2, 3'd0, 12'h010}, 2'd2, 1'b0, 32'h0);
      access(1'b0, {12'h0, 5'd2, 3'd0, 12'h0F6}, 2'd1, 1'b0, 32'h0);
      access(1'b0, {12'h0, 5'd1, 3'd0, 12'h000}, 2'd2, 1'b0, 32'h0);  // R8
      access(1'b0, {12'h0, 5'd1, 3'd0, 12'h002}, 2'd1, 1'b0, 32'h0);  // R8
      access(1'b0, {12'h0, 5'd1, 3'd0, 12'h003}, 2'd0, 1'b0, 32'h0);  // R8
      access(1'b0, {12'h0, 5'd2, 3'd1, 12'h000}, 2'd2, 1'b0, 32'h0);  // R7 function
      access(1'b0, {12'h0, 5'd20, 3'd0, 12'h000}, 2'd2, 1'b0, 32'h0); // R7 slot range
      access(1'b0, {12'h0, 5'd5, 3'd0, 12'h043}, 2'd0, 1'b1, 32'h0000_00A7); // R10
      access(1'b0, {12'h0, 5'd5, 3'd0, 12'h042}, 2'd2, 1'b1, 32'h1234_5678); // R10
      access(1'b0, {12'h0, 5'd1, 3'd0, 12'h040}, 2'd2, 1'b1, 32'hDEAD_BEEF); // R9
      // R3 errors
      access(1'b0, 32'h0010_0000, 2'd2, 1'b0, 32'h0);
      access(1'b1, 32'd8, 2'd0, 1'b0, 32'h0);
      access(1'b1, 32'd0, 2'd3, 1'b1, 32'hFFFF_FFFF);
      access(1'b1, 32'd0, 2'd2, 1'b0, 32'h0);
      // R4 R5 R6 legacy port path
      access(1'b1, 32'd0, 2'd2, 1'b1, 32'h8000_2810);
      access(1'b1, 32'd4, 2'd2, 1'b0, 32'h0);
      access(1'b1, 32'd6, 2'd1, 1'b0, 32'h0);
      access(1'b1, 32'd7, 2'd0, 1'b1, 32'h0000_0055);
      access(1'b1, 32'd1, 2'd0, 1'b1, 32'h0000_0010);
      access(1'b1, 32'd1, 2'd1, 1'b0, 32'h0);
      access(1'b1, 32'd3, 2'd1, 1'b0, 32'h0);
      access(1'b1, 32'd5, 2'd2, 1'b0, 32'h0);
      access(1'b1, 32'd2, 2'd1, 1'b1, 32'h0000_0001);
      access(1'b1, 32'd4, 2'd2, 1'b0, 32'h0);
      access(1'b1, 32'd3, 2'd1, 1'b1, 32'h0000_ABCD);
      access(1'b1, 32'd0, 2'd2, 1'b0, 32'h0);

      for (int it = 0; it < 400; it++) begin
         logic sp, wr;
         logic [1:0] sz;
         if ($urandom % 16 == 0) slot_present = 16'($urandom);
         sp = 1'($urandom % 2);
         wr = 1'($urandom % 2);
         sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
         if (sp) begin
            if ($urandom % 4 == 0) begin
               ad = {8'h80, 8'h00, 1'b0, 4'($urandom), 3'd0, 8'($urandom)};
               access(1'b1, 32'd0, 2'd2, 1'b1, ad);
            end else begin
               access(1'b1, 32'($urandom % 10), sz, wr, $urandom);
            end
         end else begin
            ad = {12'h0, 5'($urandom), ($urandom % 4 == 0) ? 3'($urandom) : 3'd0, 12'($urandom)};
            if ($urandom % 10 == 0) ad[27:20] = 8'($urandom % 15 + 1);
            access(1'b0, ad, sz, wr, $urandom);
         end
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule